// File: doc/BRIEF.md
# Vectored Priority Interrupt Controller

This block sits beside a small 8-bit CPU core and decides when the core must leave its program to serve a request, and where it must go. It accepts a parameterised number of request sources. Each source is either event-type, which captures a pulse in a pending flag, or level-type, which requests service only while its input is high. Every source has its own enable bit. One global enable gates all of them. When at least one enabled source is pending and the global enable allows it, the block raises a take strobe. In the same cycle it presents the vector address of the highest-priority source.

Taking a vector clears the global enable. A return-from-interrupt strobe sets it again. After a return, the core must retire one more instruction before another vector can be taken. A disable command blocks a take in the same cycle it is given. Software may set the global enable inside a handler, so any enabled source can then preempt that handler. A select input moves the vector table from the application base to the boot base. Each table entry is two words long. Index 0 of the table is the reset vector, and source `i` uses index `i+1`.

Top module: `irq_vector_ctrl`

## Requirements
- R1: Among pending and enabled sources, the one with the lowest index is granted, because it has the lowest vector address. Source `i` uses table index `i+1`, and index 0 is reserved for reset.
- R2: `take` is high only in a cycle where the granted source's bit in `src_en` is 1 and the global enable `gie` is 1.
- R3: In the cycle after a take, `gie` reads 0. A `reti` strobe sets `gie` to 1 on the next edge unless `gie_clr` is also high in that cycle. A take overrides every set.
- R4: For an event-type source (its bit in `LEVEL_MASK` is 0), `src_req` high at a clock edge sets its bit in `flags`. This happens whatever the enables are. The bit stays set until cleared, and the source can be granted from the following cycle onward.
- R5: A flag bit is cleared on the edge that ends a cycle in which its source was taken, or in which `flag_clr` has a 1 at that bit position.
- R6: A level-type source (its bit in `LEVEL_MASK` is 1) never sets its `flags` bit. It is pending only in cycles where its `src_req` is high, so a request that is removed before it is enabled is lost.
- R7: No take happens in a `reti` cycle. After a `reti`, takes stay blocked up to and including the first cycle with `retire` high. The earliest take is in the cycle after that one.
- R8: With `gie_clr` high, no take happens in that same cycle, and `gie` reads 0 afterwards, even if `gie_set` is also high.
- R9: `vec_addr` = base + 2·(i+1) for the granted source `i`. The base is `APP_BASE` when `vec_sel` is 0 and `BOOT_BASE` when it is 1. With no pending enabled source, `vec_addr` equals the base.
- R10: A `gie_set` strobe inside a handler sets `gie` on the next edge. A pending enabled source is then taken, so it preempts the handler.
- R11: If `src_req` and `flag_clr` hit the same event-type bit in one cycle, the flag ends up set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| src_req | input | NUM_SRC | Request inputs: pulses for event sources, levels for level sources |
| src_en | input | NUM_SRC | Per-source enable bits |
| flag_clr | input | NUM_SRC | Write-one-to-clear strobes for the pending flags |
| gie_set | input | 1 | Strobe that sets the global enable |
| gie_clr | input | 1 | Strobe that clears the global enable; it takes effect in the same cycle |
| reti | input | 1 | Return-from-interrupt strobe |
| retire | input | 1 | The core completed an instruction in this cycle |
| vec_sel | input | 1 | 0 selects the application vector base, 1 selects the boot base |
| take | output | 1 | Vector taken in this cycle |
| vec_addr | output | ADDR_W | Vector address of the granted source |
| gie | output | 1 | Global enable state |
| flags | output | NUM_SRC | Pending flags of the event sources |

## Verification
`take` and `vec_addr` are combinational, so they reflect the inputs and state of the same cycle. `flags` and `gie` change one edge after the stimulus that affects them. Only the end of the post-return block depends on the cycle after the `retire` strobe. The bench drives inputs just after the rising edge. At each falling edge it compares all four outputs with a behavioural model, which then advances its state from the inputs that the next rising edge will sample. This keeps every comparison aligned with the cycle in which its result is due.

// File: rtl/irq_pkg.sv
package irq_pkg;
   // Each vector table entry holds this many instruction words.
   localparam int unsigned ENTRY_WORDS = 2;
   // Table slot 0 belongs to reset; sources follow it.
   localparam int unsigned RESET_SLOTS = 1;

   function automatic int unsigned entry_offset(input int unsigned src_idx);
      return (src_idx + RESET_SLOTS) * ENTRY_WORDS;
   endfunction

   typedef enum logic [0:0] {
      SRC_EVENT = 1'b0,
      SRC_LEVEL = 1'b1
   } src_kind_e;
endpackage

// File: rtl/irq_flag_bank.sv
module irq_flag_bank #(
   parameter int unsigned NUM_SRC    = 8,
   parameter logic [NUM_SRC-1:0] LEVEL_MASK = '0
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [NUM_SRC-1:0] req,
   input  logic [NUM_SRC-1:0] clr,
   input  logic [NUM_SRC-1:0] taken_oh,
   output logic [NUM_SRC-1:0] flag_q,
   output logic [NUM_SRC-1:0] pending
);
   for (genvar i = 0; i < NUM_SRC; i++) begin : g_src
      if (irq_pkg::src_kind_e'(LEVEL_MASK[i]) == irq_pkg::SRC_LEVEL) begin : g_level
         logic unused_lvl;
         assign unused_lvl = clr[i] ^ taken_oh[i];
         assign flag_q[i]  = 1'b0;
         assign pending[i] = req[i];
      end else begin : g_event
         logic f_q;
         always_ff @(posedge clk) begin
            if (!rst_n)
               f_q <= 1'b0;
            else if (req[i])
               f_q <= 1'b1;
            else if (clr[i] || taken_oh[i])
               f_q <= 1'b0;
         end
         assign flag_q[i]  = f_q;
         assign pending[i] = f_q;
      end
   end
endmodule

// File: rtl/irq_prio_pick.sv
module irq_prio_pick #(
   parameter int unsigned NUM_SRC = 8,
   localparam int unsigned IDX_W  = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1
) (
   input  logic [NUM_SRC-1:0] eligible,
   output logic [NUM_SRC-1:0] grant_oh,
   output logic [IDX_W-1:0]   grant_idx,
   output logic               any
);
   always_comb begin
      grant_oh  = '0;
      grant_idx = '0;
      for (int i = NUM_SRC - 1; i >= 0; i--) begin
         if (eligible[i]) begin
            grant_oh  = '0;
            grant_oh[i] = 1'b1;
            grant_idx = IDX_W'(i);
         end
      end
   end

   assign any = |eligible;
endmodule

// File: rtl/irq_gie_ctrl.sv
module irq_gie_ctrl (
   input  logic clk,
   input  logic rst_n,
   input  logic gie_set,
   input  logic gie_clr,
   input  logic reti,
   input  logic retire,
   input  logic take,
   output logic gie_q,
   output logic allow
);
   logic hold_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         gie_q  <= 1'b0;
         hold_q <= 1'b0;
      end else begin
         if (take || gie_clr)
            gie_q <= 1'b0;
         else if (gie_set || reti)
            gie_q <= 1'b1;

         if (reti)
            hold_q <= 1'b1;
         else if (retire)
            hold_q <= 1'b0;
      end
   end

   // Disable acts in its own cycle; a return and its shadow block taking.
   assign allow = gie_q && !gie_clr && !hold_q && !reti;
endmodule

// File: rtl/irq_vec_gen.sv
module irq_vec_gen #(
   parameter int unsigned NUM_SRC   = 8,
   parameter int unsigned ADDR_W    = 16,
   parameter int unsigned APP_BASE  = 0,
   parameter int unsigned BOOT_BASE = 'h7800,
   localparam int unsigned IDX_W    = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1
) (
   input  logic [IDX_W-1:0]  grant_idx,
   input  logic              any,
   input  logic              vec_sel,
   output logic [ADDR_W-1:0] vec_addr
);
   logic [ADDR_W-1:0] base;
   logic [ADDR_W-1:0] offset;

   if (APP_BASE == BOOT_BASE) begin : g_fixed_base
      logic unused_sel;
      assign unused_sel = vec_sel;
      assign base = ADDR_W'(APP_BASE);
   end else begin : g_sel_base
      assign base = vec_sel ? ADDR_W'(BOOT_BASE) : ADDR_W'(APP_BASE);
   end

   assign offset   = any ? ADDR_W'(irq_pkg::entry_offset(32'(grant_idx))) : '0;
   assign vec_addr = base + offset;
endmodule

// File: rtl/irq_vector_ctrl.sv
module irq_vector_ctrl #(
   parameter int unsigned NUM_SRC   = 8,
   parameter int unsigned ADDR_W    = 16,
   parameter int unsigned APP_BASE  = 0,
   parameter int unsigned BOOT_BASE = 'h7800,
   parameter logic [NUM_SRC-1:0] LEVEL_MASK = 8'hC0
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [NUM_SRC-1:0] src_req,
   input  logic [NUM_SRC-1:0] src_en,
   input  logic [NUM_SRC-1:0] flag_clr,
   input  logic               gie_set,
   input  logic               gie_clr,
   input  logic               reti,
   input  logic               retire,
   input  logic               vec_sel,
   output logic               take,
   output logic [ADDR_W-1:0]  vec_addr,
   output logic               gie,
   output logic [NUM_SRC-1:0] flags
);
   localparam int unsigned IDX_W   = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1;
   localparam longint unsigned TOP_END =
      longint'(BOOT_BASE > APP_BASE ? BOOT_BASE : APP_BASE) +
      longint'(irq_pkg::entry_offset(NUM_SRC));

   if (NUM_SRC < 1 || NUM_SRC > 64) begin : g_bad_count
      $error("irq_vector_ctrl: NUM_SRC must be 1..64");
   end
   if (ADDR_W < 2 || ADDR_W > 32) begin : g_bad_width
      $error("irq_vector_ctrl: ADDR_W must be 2..32");
   end
   if (TOP_END > (64'd1 << ADDR_W)) begin : g_bad_range
      $error("irq_vector_ctrl: vector table exceeds address space");
   end
   if ((APP_BASE % 2) != 0 || (BOOT_BASE % 2) != 0) begin : g_bad_align
      $error("irq_vector_ctrl: vector bases must be even");
   end

   logic [NUM_SRC-1:0] pending;
   logic [NUM_SRC-1:0] eligible;
   logic [NUM_SRC-1:0] grant_oh;
   logic [NUM_SRC-1:0] taken_oh;
   logic [IDX_W-1:0]   grant_idx;
   logic               any;
   logic               allow;

   irq_flag_bank #(
      .NUM_SRC    (NUM_SRC),
      .LEVEL_MASK (LEVEL_MASK)
   ) u_flags (
      .clk      (clk),
      .rst_n    (rst_n),
      .req      (src_req),
      .clr      (flag_clr),
      .taken_oh (taken_oh),
      .flag_q   (flags),
      .pending  (pending)
   );

   assign eligible = pending & src_en;

   irq_prio_pick #(
      .NUM_SRC (NUM_SRC)
   ) u_pick (
      .eligible  (eligible),
      .grant_oh  (grant_oh),
      .grant_idx (grant_idx),
      .any       (any)
   );

   irq_gie_ctrl u_gie (
      .clk     (clk),
      .rst_n   (rst_n),
      .gie_set (gie_set),
      .gie_clr (gie_clr),
      .reti    (reti),
      .retire  (retire),
      .take    (take),
      .gie_q   (gie),
      .allow   (allow)
   );

   assign take     = allow && any;
   assign taken_oh = take ? grant_oh : '0;

   irq_vec_gen #(
      .NUM_SRC   (NUM_SRC),
      .ADDR_W    (ADDR_W),
      .APP_BASE  (APP_BASE),
      .BOOT_BASE (BOOT_BASE)
   ) u_vec (
      .grant_idx (grant_idx),
      .any       (any),
      .vec_sel   (vec_sel),
      .vec_addr  (vec_addr)
   );
endmodule

// File: rtl/irq_vector_ctrl_chk.sv
module irq_vector_ctrl_chk #(
   parameter int unsigned NUM_SRC   = 8,
   parameter int unsigned ADDR_W    = 16,
   parameter int unsigned APP_BASE  = 0,
   parameter int unsigned BOOT_BASE = 'h7800
) (
   input logic               clk,
   input logic               rst_n,
   input logic [NUM_SRC-1:0] src_req,
   input logic [NUM_SRC-1:0] src_en,
   input logic [NUM_SRC-1:0] flag_clr,
   input logic               gie_clr,
   input logic               reti,
   input logic               vec_sel,
   input logic               take,
   input logic [ADDR_W-1:0]  vec_addr,
   input logic               gie,
   input logic [NUM_SRC-1:0] flags,
   input logic [NUM_SRC-1:0] grant_oh
);
   logic [NUM_SRC-1:0] keep_q;

   always_ff @(posedge clk) begin
      if (!rst_n)
         keep_q <= '0;
      else
         keep_q <= flags & ~flag_clr & ~(take ? grant_oh : '0);
   end

   assert_one_grant_R1: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(grant_oh));

   assert_take_gated_R2: assert property (@(posedge clk) disable iff (!rst_n)
      take |-> (gie && ((grant_oh & src_en) != '0)));

   assert_gie_drop_R3: assert property (@(posedge clk) disable iff (!rst_n)
      take |=> !gie);

   assert_reti_sets_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (reti && !gie_clr) |=> gie);

   assert_flag_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (keep_q & ~flags) == '0);

   assert_hw_clear_R5: assert property (@(posedge clk) disable iff (!rst_n)
      take |=> ((flags & $past(grant_oh & ~src_req)) == '0));

   assert_reti_shadow_R7: assert property (@(posedge clk) disable iff (!rst_n)
      reti |=> !take);

   assert_cli_blocks_R8: assert property (@(posedge clk) disable iff (!rst_n)
      gie_clr |-> !take);

   assert_vec_above_reset_R9: assert property (@(posedge clk) disable iff (!rst_n)
      take |-> ((vec_addr > (vec_sel ? ADDR_W'(BOOT_BASE) : ADDR_W'(APP_BASE)))
                && !vec_addr[0]));
endmodule

bind irq_vector_ctrl irq_vector_ctrl_chk #(
   .NUM_SRC   (NUM_SRC),
   .ADDR_W    (ADDR_W),
   .APP_BASE  (APP_BASE),
   .BOOT_BASE (BOOT_BASE)
) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .src_req  (src_req),
   .src_en   (src_en),
   .flag_clr (flag_clr),
   .gie_clr  (gie_clr),
   .reti     (reti),
   .vec_sel  (vec_sel),
   .take     (take),
   .vec_addr (vec_addr),
   .gie      (gie),
   .flags    (flags),
   .grant_oh (grant_oh)
);

// File: tb/tb_irq_vector_ctrl.sv
`timescale 1ns/1ps
module tb_irq_vector_ctrl;
   localparam int N      = 8;
   localparam int AW     = 16;
   localparam int APP    = 0;
   localparam int BOOT   = 'h7800;
   localparam logic [N-1:0] LVL = 8'hC0;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic [N-1:0]  src_req = '0, src_en = '0, flag_clr = '0;
   logic          gie_set = 0, gie_clr = 0, reti = 0, retire = 0, vec_sel = 0;
   logic          take, gie;
   logic [AW-1:0] vec_addr;
   logic [N-1:0]  flags;

   int total = 0;
   int fails = 0;
   bit run = 0;
   string tag = "reset";

   // behavioural reference state
   bit [N-1:0] m_flags = '0;
   bit         m_gie = 0;
   bit         m_hold = 0;

   always #4 clk = ~clk;   // 125 MHz

   irq_vector_ctrl #(
      .NUM_SRC(N), .ADDR_W(AW), .APP_BASE(APP), .BOOT_BASE(BOOT), .LEVEL_MASK(LVL)
   ) dut (
      .clk(clk), .rst_n(rst_n), .src_req(src_req), .src_en(src_en),
      .flag_clr(flag_clr), .gie_set(gie_set), .gie_clr(gie_clr), .reti(reti),
      .retire(retire), .vec_sel(vec_sel), .take(take), .vec_addr(vec_addr),
      .gie(gie), .flags(flags)
   );

   task automatic check(input string what, input longint act, input longint exp);
      total++;
      if (act != exp) begin
         fails++;
         $display("FAIL %s %s: actual %0h expected %0h at %0t", tag, what, act, exp, $time);
      end
   endtask

   always @(negedge clk) begin
      if (run) begin
         int first;
         bit found;
         bit e_take;
         int e_vec;
         bit [N-1:0] nf;
         found = 0;
         first = 0;
         for (int i = N - 1; i >= 0; i--) begin
            bit p;
            p = LVL[i] ? src_req[i] : m_flags[i];
            if (p && src_en[i]) begin
               found = 1;
               first = i;
            end
         end
         e_take = m_gie && !gie_clr && !m_hold && !reti && found;
         e_vec  = (vec_sel ? BOOT : APP) + (found ? 2 * (first + 1) : 0);
         check("take", take, e_take);
         check("vec_addr", vec_addr, e_vec);
         check("gie", gie, m_gie);
         check("flags", flags, m_flags);
         for (int i = 0; i < N; i++) begin
            if (LVL[i]) nf[i] = 0;
            else nf[i] = src_req[i] | (m_flags[i] & !flag_clr[i] & !(e_take && first == i));
         end
         m_flags = nf;
         if (e_take || gie_clr) m_gie = 0;
         else if (gie_set || reti) m_gie = 1;
         if (reti) m_hold = 1;
         else if (retire) m_hold = 0;
      end
   end

   task automatic cyc(input int n);
      repeat (n) @(posedge clk);
      #1;
   endtask

   task automatic clear_strobes();
      flag_clr = '0; gie_set = 0; gie_clr = 0; reti = 0; retire = 0;
   endtask

   initial begin
      repeat (50000) @(posedge clk);
      fails++;
      total++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
   end

   initial begin
      cyc(3);
      @(negedge clk);
      tag = "reset";
      check("take", take, 0);
      check("gie", gie, 0);
      check("flags", flags, 0);
      check("vec_addr", vec_addr, APP);
      @(posedge clk); #1;
      rst_n = 1;
      run = 1;

      // R4: event flag captured and held while disabled
      tag = "R4";
      src_req[3] = 1; cyc(1); src_req[3] = 0; cyc(3);

      // R2: individual enable alone is not enough; then global enable allows take
      tag = "R2";
      src_en[3] = 1; cyc(2);
      gie_set = 1; cyc(1); clear_strobes(); cyc(3);

      // R3: return sets the global enable again
      tag = "R3";
      reti = 1; cyc(1); clear_strobes();
      retire = 1; cyc(1); clear_strobes(); cyc(2);

      // R1: two pending sources, lower index first (gie already set)
      tag = "R1";
      src_en = 8'h2A;
      gie_clr = 1; cyc(1); clear_strobes();
      src_req[1] = 1; src_req[5] = 1; cyc(1); src_req = '0; cyc(1);
      gie_set = 1; cyc(1); clear_strobes(); cyc(3);

      // R5: software clears the remaining flag
      tag = "R5";
      flag_clr[5] = 1; cyc(1); clear_strobes(); cyc(2);

      // R11: set and clear hit the same bit together
      tag = "R11";
      src_req[2] = 1; flag_clr[2] = 1; cyc(1); src_req = '0; clear_strobes(); cyc(2);
      flag_clr[2] = 1; cyc(1); clear_strobes(); cyc(1);

      // R6: level source lost when withdrawn before enable, served while present
      tag = "R6";
      src_req[6] = 1; cyc(2); src_req[6] = 0; cyc(1);
      src_en[6] = 1; gie_set = 1; cyc(1); clear_strobes(); cyc(2);
      src_req[6] = 1; cyc(1); src_req[6] = 0; cyc(2);

      // R7: one instruction must retire after a return before a new take
      tag = "R7";
      src_en[0] = 1; src_req[0] = 1; cyc(1); src_req = '0;
      reti = 1; cyc(1); clear_strobes(); cyc(2);
      retire = 1; cyc(1); clear_strobes(); cyc(2);

      // R8: disable wins over set, and blocks a take in its own cycle
      tag = "R8";
      src_en[4] = 0; src_req[4] = 1; cyc(1); src_req = '0;
      gie_set = 1; gie_clr = 1; cyc(1); clear_strobes(); cyc(1);
      gie_set = 1; cyc(1); clear_strobes(); cyc(1);
      src_en[4] = 1; gie_clr = 1; cyc(1); clear_strobes(); cyc(2);

      // R9: boot base selected
      tag = "R9";
      vec_sel = 1; cyc(1);
      gie_set = 1; cyc(1); clear_strobes(); cyc(2);

      // R10: handler re-enables and a pending source nests
      tag = "R10";
      src_req[0] = 1; cyc(1); src_req = '0; cyc(1);
      gie_set = 1; cyc(1); clear_strobes(); cyc(3);

      run = 0;
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
   end
endmodule